// File: doc/BRIEF.md
# PRBS Receive Synchronisation Monitor

This block checks a received serial stream against a locally generated 2^15-1 pseudo-random sequence, built from the recurrence b[n] = b[n-15] XOR b[n-14]. Received bits arrive one at a time under a valid strobe. They are optionally inverted first and then compared with the bit the local reference predicts. While the monitor has not locked, the reference register fills itself from the incoming bits. It can therefore align to any phase of the sequence without a seed. Once locked, the reference advances on its own.

Lock is judged over fixed, back-to-back windows of 64 valid bits. At each window boundary the error total of that window decides the new sync state. A window with at most 6 errors keeps or gains lock, so lock survives error rates of about one in ten. A change of sync state can set a sticky interrupt flag. The flag can be set either by gaining lock only or by any change, and a mask gates it onto an interrupt line. A 16-bit saturating counter tallies bit errors when its source select is 00.

Top module: `prbs_sync_mon`

## Requirements
- R1: Windows are consecutive groups of 64 valid bits counted from reset. `sync_o` changes only on the clock edge that takes the 64th bit of a window. It becomes 1 when that window held 6 or fewer errors.
- R2: A window with 7 or more errors sets `sync_o` to 0 at its closing edge.
- R3: The expected bit is the XOR of the bits received 15 and 14 positions earlier. While out of sync the reference loads received bits. While in sync it loads its own predictions. An all-zero reference state counts every bit as an error, so a constant-zero stream never reaches sync.
- R4: With `invert_i` = 1 each received bit is inverted before the comparison, so an inverted sequence is accepted as clean.
- R5: One clock after `sync_o` changes, `irq_stat_o` is set. With `irq_any_edge_i` = 0 this happens only for a 0-to-1 change. With `irq_any_edge_i` = 1 it happens for either direction.
- R6: `irq_stat_o` stays 1 until a cycle with `irq_clr_i` = 1 and no new set. `irq_o` is `irq_stat_o` AND `irq_mask_i`.
- R7: When `err_sel_i` = 2'b00, every valid bit in error adds 1 to `err_cnt_o`. Other select values leave it unchanged. The counter holds at 16'hFFFF, and `cnt_clr_i` = 1 clears it to 0, which takes priority over counting.
- R8: Cycles with `bit_vld_i` = 0 change neither the reference, the window position, the sync state nor the counter.
- R9: After reset `sync_o`, `irq_stat_o`, `irq_o` and `err_cnt_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_bit_i | input | 1 | Received data bit |
| bit_vld_i | input | 1 | Qualifies `rx_bit_i` in this cycle |
| invert_i | input | 1 | Invert received bits before comparison |
| irq_any_edge_i | input | 1 | 0: set flag on gaining sync; 1: on any change |
| irq_mask_i | input | 1 | Enables the interrupt line |
| err_sel_i | input | 2 | Error counter source; 00 counts pattern errors |
| irq_clr_i | input | 1 | Clears the latched interrupt flag |
| cnt_clr_i | input | 1 | Clears the error counter |
| sync_o | output | 1 | Pattern sync status |
| irq_stat_o | output | 1 | Latched sync-change flag |
| irq_o | output | 1 | Masked interrupt |
| err_cnt_o | output | 16 | Saturating error count |

## Verification
The first stimulus is a clean sequence started from an empty reference. It shows that self-alignment gives lock within two windows. Window-aligned bursts of exactly 6 and exactly 7 errors sit on either side of the threshold and show where the boundary lies. A clean window after a loss shows that the free-running reference was kept. An inverted stream with `invert_i` set tells correct inversion apart from an ignored control. Rows that flip the edge mode tell rising-only capture apart from any-change capture. Invalid cycles carrying junk, followed by a clean window, would expose a strobe leak as misalignment. A long constant-zero stream shows both the lock-up guard and counter saturation.

// File: rtl/prbs_mon_pkg.sv
package prbs_mon_pkg;
  localparam int unsigned PRBS_LEN = 15;
  localparam int unsigned TAP_OLD  = 14;  // b[n-15]
  localparam int unsigned TAP_NEXT = 13;  // b[n-14]
  localparam int unsigned WIN_LEN  = 64;
  localparam int unsigned MAX_ERR  = 6;
  localparam int unsigned CNT_W    = 16;

  typedef enum logic [1:0] {
    ERR_SRC_PRBS = 2'b00,
    ERR_SRC_R1   = 2'b01,
    ERR_SRC_R2   = 2'b10,
    ERR_SRC_R3   = 2'b11
  } err_src_e;
endpackage

// File: rtl/prbs_ref_gen.sv
module prbs_ref_gen
  import prbs_mon_pkg::*;
#(
  parameter int unsigned LEN = PRBS_LEN,
  parameter int unsigned TA  = TAP_OLD,
  parameter int unsigned TB  = TAP_NEXT
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vld_i,
  input  logic bit_i,
  input  logic sync_i,
  output logic err_o
);
  logic [LEN-1:0] ref_q;
  logic           pred;

  assign pred  = ref_q[TA] ^ ref_q[TB];
  // zero state is the LFSR lock-up point: treat as permanent mismatch (R3)
  assign err_o = (ref_q == '0) | (bit_i != pred);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ref_q <= '0;
    else if (vld_i) ref_q <= {ref_q[LEN-2:0], sync_i ? pred : bit_i};
  end

  assert_hold_when_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(vld_i) |-> $stable(ref_q));
endmodule

// File: rtl/prbs_win_judge.sv
module prbs_win_judge
  import prbs_mon_pkg::*;
#(
  parameter int unsigned WLEN = WIN_LEN,
  parameter int unsigned MERR = MAX_ERR
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vld_i,
  input  logic err_i,
  output logic sync_o
);
  localparam int unsigned CW   = $clog2(WLEN);
  localparam int unsigned TW   = $clog2(MERR + 2);
  localparam int unsigned SUMW = TW + 1;
  localparam logic [CW-1:0] LAST = CW'(WLEN - 1);
  localparam logic [TW-1:0] SAT  = TW'(MERR + 1);

  logic [CW-1:0]   pos_q;
  logic [TW-1:0]   tally_q;
  logic [SUMW-1:0] total;
  logic            win_end;

  assign win_end = vld_i && (pos_q == LAST);
  assign total   = SUMW'(tally_q) + SUMW'(err_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q   <= '0;
      tally_q <= '0;
      sync_o  <= 1'b0;
    end else if (vld_i) begin
      pos_q <= (pos_q == LAST) ? '0 : pos_q + 1'b1;
      if (win_end) begin
        tally_q <= '0;
        sync_o  <= (total <= SUMW'(MERR));
      end else if (err_i && tally_q != SAT) begin
        tally_q <= tally_q + 1'b1;
      end
    end
  end

  assert_sync_at_boundary_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_o != $past(sync_o)) |-> $past(win_end));
  assert_tally_bounded_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tally_q <= SAT);
endmodule

// File: rtl/prbs_irq_latch.sv
module prbs_irq_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  input  logic any_edge_i,
  input  logic mask_i,
  input  logic clr_i,
  output logic stat_o,
  output logic irq_o
);
  logic sync_d_q;
  logic set_ev;

  assign set_ev = (sync_i & ~sync_d_q) | (any_edge_i & ~sync_i & sync_d_q);
  assign irq_o  = stat_o & mask_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_d_q <= 1'b0;
      stat_o   <= 1'b0;
    end else begin
      sync_d_q <= sync_i;
      if (set_ev)     stat_o <= 1'b1;
      else if (clr_i) stat_o <= 1'b0;
    end
  end

  assert_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(stat_o) && !$past(clr_i)) |-> stat_o);
  assert_rise_only_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(stat_o) && !$past(any_edge_i)) |-> $past(sync_i));
endmodule

// File: rtl/prbs_err_cnt.sv
module prbs_err_cnt
  import prbs_mon_pkg::*;
#(
  parameter int unsigned W = CNT_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         vld_i,
  input  logic         err_i,
  input  logic [1:0]   sel_i,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] FULL = '1;

  logic inc;
  assign inc = vld_i && err_i && (sel_i == ERR_SRC_PRBS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_o <= '0;
    else if (clr_i)                cnt_o <= '0;
    else if (inc && cnt_o != FULL) cnt_o <= cnt_o + 1'b1;
  end

  assert_no_wrap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(cnt_o) == FULL && !$past(clr_i)) |-> cnt_o == FULL);
  assert_step_one_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o != $past(cnt_o)) |-> (cnt_o == $past(cnt_o) + 1'b1 || cnt_o == '0));
endmodule

// File: rtl/prbs_sync_mon.sv
module prbs_sync_mon
  import prbs_mon_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        rx_bit_i,
  input  logic        bit_vld_i,
  input  logic        invert_i,
  input  logic        irq_any_edge_i,
  input  logic        irq_mask_i,
  input  logic [1:0]  err_sel_i,
  input  logic        irq_clr_i,
  input  logic        cnt_clr_i,
  output logic        sync_o,
  output logic        irq_stat_o,
  output logic        irq_o,
  output logic [15:0] err_cnt_o
);
  logic cmp_bit;
  logic bit_err;

  assign cmp_bit = rx_bit_i ^ invert_i;

  prbs_ref_gen i_ref (
    .clk_i (clk_i), .rst_ni(rst_ni), .vld_i(bit_vld_i),
    .bit_i (cmp_bit), .sync_i(sync_o), .err_o(bit_err)
  );

  prbs_win_judge i_judge (
    .clk_i (clk_i), .rst_ni(rst_ni), .vld_i(bit_vld_i),
    .err_i (bit_err), .sync_o(sync_o)
  );

  prbs_irq_latch i_irq (
    .clk_i (clk_i), .rst_ni(rst_ni), .sync_i(sync_o),
    .any_edge_i(irq_any_edge_i), .mask_i(irq_mask_i), .clr_i(irq_clr_i),
    .stat_o(irq_stat_o), .irq_o(irq_o)
  );

  prbs_err_cnt #(.W(16)) i_cnt (
    .clk_i (clk_i), .rst_ni(rst_ni), .vld_i(bit_vld_i), .err_i(bit_err),
    .sel_i (err_sel_i), .clr_i(cnt_clr_i), .cnt_o(err_cnt_o)
  );
endmodule

// File: tb/test_prbs_sync_mon.sv
module test_prbs_sync_mon;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_bit = 1'b0, bit_vld = 1'b0, invert = 1'b0;
  logic        any_edge = 1'b0, mask = 1'b1, irq_clr = 1'b0, cnt_clr = 1'b0;
  logic [1:0]  err_sel = 2'b01;
  logic        sync, irq_stat, irq;
  logic [15:0] err_cnt;

  int unsigned errors = 0, checks = 0;
  logic [14:0] hist = 15'h0001;
  bit          done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prbs_sync_mon i_prbs_sync_mon (
    .clk_i(clk), .rst_ni(rst_n), .rx_bit_i(rx_bit), .bit_vld_i(bit_vld),
    .invert_i(invert), .irq_any_edge_i(any_edge), .irq_mask_i(mask),
    .err_sel_i(err_sel), .irq_clr_i(irq_clr), .cnt_clr_i(cnt_clr),
    .sync_o(sync), .irq_stat_o(irq_stat), .irq_o(irq), .err_cnt_o(err_cnt)
  );

  typedef struct packed {
    int unsigned nbits;
    int unsigned nerr;
    bit          inv;
    bit          edge_any;
    logic [1:0]  sel;
    bit          exp_sync;
    bit          exp_irq;
    int unsigned exp_cnt;
  } row_t;

  // acquire, 6-err hold, 7-err loss (rise-only), regain, inverted, loss (any edge), regain
  localparam row_t ROWS [7] = '{
    '{128, 0, 1'b0, 1'b0, 2'b01, 1'b1, 1'b1, 0},
    '{ 64, 6, 1'b0, 1'b0, 2'b00, 1'b1, 1'b0, 6},
    '{ 64, 7, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 13},
    '{ 64, 0, 1'b0, 1'b0, 2'b00, 1'b1, 1'b1, 13},
    '{ 64, 0, 1'b1, 1'b0, 2'b00, 1'b1, 1'b0, 13},
    '{ 64, 7, 1'b0, 1'b1, 2'b00, 1'b0, 1'b1, 20},
    '{ 64, 0, 1'b0, 1'b0, 2'b00, 1'b1, 1'b1, 20}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic next_prbs();
    logic b;
    b = hist[14] ^ hist[13];
    hist = {hist[13:0], b};
    return b;
  endfunction

  task automatic send_bit(input logic b);
    rx_bit  = b;
    bit_vld = 1'b1;
    @(negedge clk);
  endtask

  task automatic settle();
    bit_vld = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse_irq_clr();
    irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 sync", sync, 0);
    check("R9 irq_stat", irq_stat, 0);
    check("R9 irq", irq, 0);
    check("R9 err_cnt", err_cnt, 0);
    rst_n = 1'b1;
    @(negedge clk);

    foreach (ROWS[r]) begin
      pulse_irq_clr();
      invert   = ROWS[r].inv;
      any_edge = ROWS[r].edge_any;
      err_sel  = ROWS[r].sel;
      for (int i = 0; i < int'(ROWS[r].nbits); i++) begin
        logic b;
        logic flip;
        b = next_prbs();
        flip = (i % 5 == 2) && (i / 5 < int'(ROWS[r].nerr));
        send_bit(b ^ ROWS[r].inv ^ flip);
      end
      settle();
      // R1 R2 R3 R4 window outcome, R5 R6 flag, R7 count
      check($sformatf("R1/R2/R4 row%0d sync", r), sync, ROWS[r].exp_sync);
      check($sformatf("R5 row%0d irq_stat", r), irq_stat, ROWS[r].exp_irq);
      check($sformatf("R6 row%0d irq", r), irq, ROWS[r].exp_irq);
      check($sformatf("R7 row%0d err_cnt", r), err_cnt, ROWS[r].exp_cnt);
    end
    invert = 1'b0; any_edge = 1'b0;

    // R6: mask gates line, flag held until cleared
    mask = 1'b0; @(negedge clk);
    check("R6 masked irq", irq, 0);
    check("R6 flag held", irq_stat, 1);
    pulse_irq_clr(); @(negedge clk);
    check("R6 flag cleared", irq_stat, 0);
    mask = 1'b1;

    // R8: invalid cycles with junk must not shift the reference or window
    for (int i = 0; i < 9; i++) begin
      rx_bit = i[0]; bit_vld = 1'b0; @(negedge clk);
    end
    for (int i = 0; i < 64; i++) send_bit(next_prbs());
    settle();
    check("R8 sync kept", sync, 1);
    check("R8 err_cnt kept", err_cnt, 20);

    // R7 other select: corrupted window not counted
    err_sel = 2'b10;
    for (int i = 0; i < 64; i++) send_bit(next_prbs() ^ (i < 3));
    settle();
    check("R7 sel10 no count", err_cnt, 20);
    check("R1 3-error window holds", sync, 1);

    // R3 zero stream never syncs; R7 saturation
    err_sel = 2'b00;
    for (int i = 0; i < 66048; i++) send_bit(1'b0);
    settle();
    check("R3 zero stream no sync", sync, 0);
    check("R7 saturated", err_cnt, 16'hFFFF);
    cnt_clr = 1'b1; @(negedge clk); cnt_clr = 1'b0; @(negedge clk);
    check("R7 cleared", err_cnt, 0);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule